// File: doc/BRIEF.md
# Dual-Enable Synchronous Counter Stage

This block is one cascadable stage of a fully synchronous counter. Every register shares one clock edge and no register output clocks another. The stage advances only when two count enables are both high. The first, `cnt_en`, is a local gate that a system holds low to freeze a whole chain. The second, `chain_en`, is the carry-in from the next less significant stage. The stage raises `carry_out` when it sits on its terminal value and `chain_en` is high. Wiring that output to `chain_en` of the next stage builds a wider counter.

The next value comes from a toggle network: a bit flips when every lower bit is 1, and bit 0 always flips. A parameter picks one of two toggle networks. The parallel network decodes each toggle term with a single wide AND. The chained network passes one link through the bits, which costs one gate per bit. Both networks give the same count sequence. A second parameter picks the wrap: binary (modulo 2^WIDTH) or decade (modulo 10). In decade mode the stage moves from 1001 straight to 0000 on the same enabled edge, so 1010 is never reached.

The stage has three behavioural states:
- CLEARED: entered on any edge where `clr_n` is low.
- COUNTING: an edge with both enables high.
- HOLDING: an edge where either enable is low.

The transitions are:
- CLEAR: taken on any edge where `clr_n` is low, whatever the enables are.
- STEP: taken on an edge with both enables high. It leads to the next value, or to 0 when the stage is at its terminal value.
- HOLD: taken on an edge where either enable is low. It keeps the count.

Top module: `tally_stage`

## Requirements
- R1: When `clr_n` is low at a rising edge, `count` is 0 after that edge, whatever the values of `cnt_en` and `chain_en`.
- R2: When `clr_n` is high and both `cnt_en` and `chain_en` are 1 at a rising edge, `count` advances by one.
- R3: When `clr_n` is high and either enable is 0 at a rising edge, `count` keeps its value.
- R4: In binary mode, a stepping edge at the all-ones value (1111 for WIDTH 4) gives 0000.
- R5: In decade mode, a stepping edge at 1001 gives 0000. After a clear, `count` never exceeds 1001.
- R6: `carry_out` is 1 exactly when `chain_en` is 1 and `count` holds the terminal value (all ones in binary mode, 1001 in decade mode). It does not depend on `cnt_en`.
- R7: The chained toggle network and the parallel toggle network give identical `count` and `carry_out` under identical inputs.
- R8: In a two-stage cascade, where the low stage's `carry_out` drives the high stage's `chain_en` and both share `cnt_en`, the pair counts 0 through 255 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by every register |
| clr_n | input | 1 | Synchronous clear, active low, takes priority over counting |
| cnt_en | input | 1 | Local count gate |
| chain_en | input | 1 | Carry-in from the previous stage; also qualifies `carry_out` |
| count | output | WIDTH | Current count value |
| carry_out | output | 1 | Terminal value reached while `chain_en` is high |

## Verification
Clear and a stepping edge can fall on the same edge. The random stimulus drops `clr_n` while both enables are high, and the bench expects 0 rather than the incremented value. A stepping edge can also coincide with the terminal value, where the wrap and the carry both act. The directed runs walk every stage through that value with both enables high. The bench checks that the count returns to 0 after the edge, and that before the edge the carry followed `chain_en` whatever `cnt_en` was.

// File: rtl/tally_pkg.sv
package tally_pkg;
    typedef enum logic {
        CARRY_PARALLEL = 1'b0,
        CARRY_CHAINED  = 1'b1
    } carry_form_e;

    typedef enum logic {
        WRAP_BINARY = 1'b0,
        WRAP_DECADE = 1'b1
    } wrap_mode_e;

    localparam int DECADE_LAST = 9;
endpackage

// File: rtl/tally_toggle_net.sv
module tally_toggle_net
    import tally_pkg::*;
#(
    parameter int          WIDTH      = 4,
    parameter carry_form_e CARRY_FORM = CARRY_PARALLEL
) (
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] tog,
    output logic             all_ones
);
    generate
        if (CARRY_FORM == CARRY_PARALLEL) begin : g_parallel
            // each toggle term is one wide AND of the lower bits
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                if (i == 0) begin : g_lsb
                    assign tog[i] = 1'b1;
                end else begin : g_upper
                    assign tog[i] = &q[i-1:0];
                end
            end
            assign all_ones = &q;
        end else begin : g_chained
            // one link per bit; the carry walks up the chain
            logic [WIDTH:0] link;
            assign link[0] = 1'b1;
            for (genvar i = 0; i < WIDTH; i++) begin : g_link
                assign link[i+1] = link[i] & q[i];
            end
            assign tog      = link[WIDTH-1:0];
            assign all_ones = link[WIDTH];
        end
    endgenerate
endmodule

// File: rtl/tally_wrap.sv
module tally_wrap
    import tally_pkg::*;
#(
    parameter int         WIDTH     = 4,
    parameter wrap_mode_e WRAP_MODE = WRAP_BINARY
) (
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] tog,
    input  logic             all_ones,
    output logic [WIDTH-1:0] nxt,
    output logic             at_last
);
    generate
        if (WRAP_MODE == WRAP_BINARY) begin : g_binary
            assign at_last = all_ones;
            assign nxt     = q ^ tog;
        end else begin : g_decade
            // the wrap is decided before the edge, so 1010 is never loaded
            assign at_last = (q == WIDTH'(DECADE_LAST));
            assign nxt     = at_last ? '0 : (q ^ tog);
        end
    endgenerate
endmodule

// File: rtl/tally_stage.sv
module tally_stage
    import tally_pkg::*;
#(
    parameter int          WIDTH      = 4,
    parameter wrap_mode_e  WRAP_MODE  = WRAP_BINARY,
    parameter carry_form_e CARRY_FORM = CARRY_PARALLEL
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] tog;
    logic [WIDTH-1:0] nxt;
    logic             all_ones;
    logic             at_last;
    logic             step;

    tally_toggle_net #(
        .WIDTH      (WIDTH),
        .CARRY_FORM (CARRY_FORM)
    ) u_toggle (
        .q        (cnt_q),
        .tog      (tog),
        .all_ones (all_ones)
    );

    tally_wrap #(
        .WIDTH     (WIDTH),
        .WRAP_MODE (WRAP_MODE)
    ) u_wrap (
        .q        (cnt_q),
        .tog      (tog),
        .all_ones (all_ones),
        .nxt      (nxt),
        .at_last  (at_last)
    );

    assign step = cnt_en & chain_en;

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= nxt;
        end
    end

    always_comb begin
        count     = cnt_q;
        carry_out = chain_en & at_last;
    end
endmodule

// File: rtl/tally_stage_chk.sv
module tally_stage_chk
    import tally_pkg::*;
#(
    parameter int         WIDTH     = 4,
    parameter wrap_mode_e WRAP_MODE = WRAP_BINARY
) (
    input logic             clk,
    input logic             clr_n,
    input logic             cnt_en,
    input logic             chain_en,
    input logic [WIDTH-1:0] count,
    input logic             carry_out
);
    localparam logic [WIDTH-1:0] LAST =
        (WRAP_MODE == WRAP_DECADE) ? WIDTH'(DECADE_LAST) : {WIDTH{1'b1}};

    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        armed <= armed | !clr_n;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (count == '0)); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && cnt_en && chain_en && count != LAST) |=> (count == $past(count) + 1'b1)); // R2
    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !(cnt_en && chain_en)) |=> $stable(count)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && cnt_en && chain_en && count == LAST) |=> (count == '0)); // R4
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!armed)
        count <= LAST); // R5
    AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (!armed)
        carry_out == (chain_en && count == LAST)); // R6
endmodule

bind tally_stage tally_stage_chk #(
    .WIDTH     (WIDTH),
    .WRAP_MODE (WRAP_MODE)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .cnt_en    (cnt_en),
    .chain_en  (chain_en),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/tally_stage_bench.sv
module tally_stage_bench;
    import tally_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [3:0] q_bin, q_binc, q_dec, q_decc, q_lo, q_hi;
    logic       c_bin, c_binc, c_dec, c_decc, c_lo, c_hi;

    int n_checks = 0;
    int n_fail   = 0;
    int m_bin = 0, m_dec = 0, m_casc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tally_stage #(.WIDTH(4), .WRAP_MODE(WRAP_BINARY), .CARRY_FORM(CARRY_PARALLEL)) u_tally_stage (
        .clk(clk), .clr_n(clr_n), .cnt_en(en_p), .chain_en(en_t), .count(q_bin), .carry_out(c_bin));
    tally_stage #(.WIDTH(4), .WRAP_MODE(WRAP_BINARY), .CARRY_FORM(CARRY_CHAINED)) u_bin_chain (
        .clk(clk), .clr_n(clr_n), .cnt_en(en_p), .chain_en(en_t), .count(q_binc), .carry_out(c_binc));
    tally_stage #(.WIDTH(4), .WRAP_MODE(WRAP_DECADE), .CARRY_FORM(CARRY_PARALLEL)) u_dec_par (
        .clk(clk), .clr_n(clr_n), .cnt_en(en_p), .chain_en(en_t), .count(q_dec), .carry_out(c_dec));
    tally_stage #(.WIDTH(4), .WRAP_MODE(WRAP_DECADE), .CARRY_FORM(CARRY_CHAINED)) u_dec_chain (
        .clk(clk), .clr_n(clr_n), .cnt_en(en_p), .chain_en(en_t), .count(q_decc), .carry_out(c_decc));
    tally_stage #(.WIDTH(4), .WRAP_MODE(WRAP_BINARY), .CARRY_FORM(CARRY_CHAINED)) u_casc_lo (
        .clk(clk), .clr_n(clr_n), .cnt_en(en_p), .chain_en(1'b1), .count(q_lo), .carry_out(c_lo));
    tally_stage #(.WIDTH(4), .WRAP_MODE(WRAP_BINARY), .CARRY_FORM(CARRY_PARALLEL)) u_casc_hi (
        .clk(clk), .clr_n(clr_n), .cnt_en(en_p), .chain_en(c_lo), .count(q_hi), .carry_out(c_hi));

    function automatic int next_val(int cur, int modulus, bit clr, bit p, bit t);
        if (!clr) return 0;
        if (p && t) return (cur + 1) % modulus;
        return cur;
    endfunction

    function automatic bit exp_carry(int cur, int last, bit t);
        return t && (cur == last);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(bit clr, bit p, bit t, string tag);
        @(negedge clk);
        clr_n = clr; en_p = p; en_t = t;
        @(posedge clk);
        m_bin  = next_val(m_bin, 16, clr, p, t);
        m_dec  = next_val(m_dec, 10, clr, p, t);
        m_casc = next_val(m_casc, 256, clr, p, 1'b1);
        #1;
        chk({tag, " R4 binary count"}, int'(q_bin), m_bin);
        chk({tag, " R7 chained binary"}, int'(q_binc), int'(q_bin));
        chk({tag, " R5 decade count"}, int'(q_dec), m_dec);
        chk({tag, " R7 chained decade"}, int'(q_decc), int'(q_dec));
        chk({tag, " R6 binary carry"}, int'(c_bin), int'(exp_carry(m_bin, 15, t)));
        chk({tag, " R6 decade carry"}, int'(c_dec), int'(exp_carry(m_dec, 9, t)));
        chk({tag, " R7 chained carry"}, int'(c_decc), int'(c_dec));
        chk({tag, " R8 cascade"}, int'({q_hi, q_lo}), m_casc);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: clear with both enables high
        step(1'b0, 1'b1, 1'b1, "R1 clear");
        chk("R1 reset value", int'(q_bin), 0);
        // R2 / R4 / R5 / R8: full run, every stage passes its terminal value
        for (int i = 0; i < 260; i++) step(1'b1, 1'b1, 1'b1, "R2 run");
        // R3: each enable low alone keeps the count
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, "R3 hold p");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, "R3 hold t");
        // R6: park decade at 9, carry follows chain_en regardless of cnt_en
        step(1'b0, 1'b0, 1'b0, "R1 clear again");
        for (int i = 0; i < 9; i++) step(1'b1, 1'b1, 1'b1, "R2 to nine");
        step(1'b1, 1'b0, 1'b1, "R6 carry p low");
        step(1'b1, 1'b0, 1'b0, "R6 carry t low");
        step(1'b1, 1'b1, 1'b1, "R5 decade wrap");
        chk("R5 wrap to zero", int'(q_dec), 0);
        // random mix, clear sometimes lands on stepping edges
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 20) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0, "rand");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule